// File: doc/BRIEF.md
# Packet Egress Transmitter with Packet-Level Flow Control

This block moves complete packets from an upstream packet store to a downstream receiver over a 32-bit word bus. Each cycle that carries a word raises a transmit-enable qualifier. The first word of every packet is marked by a one-cycle start strobe. An optional odd parity bit covers the data word. The upstream side presents the head word of its store together with an end-of-packet marker and a flag that says a whole packet is waiting. The transmitter pulls one word per cycle with a pop strobe. It never begins a packet that is not fully present.

The receiver governs the flow with a packet-available level. While it is high, packets stream out and may follow each other with no idle cycle. When the receiver drops it, a drain counter lets at most four more words out and then parks the sequencer. The packet resumes from the next word as soon as the receiver is ready again. The transmit-enable line in the cycle after a packet's last word therefore tells the receiver whether another packet follows at once.

The sequencer has three states. ST_IDLE waits for a new packet. ST_BODY sends the remaining words of the current packet. ST_HOLD is the paused state after the drain allowance is used up. The transitions are as follows:
- idle-to-idle: a single-word packet is sent.
- idle-to-body: the first word of a longer packet is sent.
- body-to-body: a middle word is sent.
- body-to-idle: the last word is sent.
- body-to-hold: the allowance is exhausted.
- hold-to-body or hold-to-idle: readiness returns and a word is sent.

Top module: `pkt_egress_tx`

## Requirements
- R1: A synchronous active-high reset clears tx_data, tx_par, tx_sop and tx_en to 0 and returns the sequencer to ST_IDLE.
- R2: A packet starts only in a cycle where rx_avail and src_ready are both sampled high. No word is sent while either is low in ST_IDLE.
- R3: tx_sop is high for exactly one cycle per packet, in the cycle that carries that packet's first word, and only when tx_en is high.
- R4: tx_en is high in every cycle that carries a word. Words appear one cycle after they are popped, in pop order and unchanged, with bit 31 as the most significant bit.
- R5: With par_en high, tx_par makes the count of ones over tx_data[31:0] and tx_par odd, in the same cycle as the data it covers.
- R6: With par_en low, tx_par is 0.
- R7: Once rx_avail is sampled low, at most four further words are sent. For a packet with enough words left, tx_en goes low at the fifth sampled edge, four cycles after the first word sent during the withdrawal.
- R8: When rx_avail returns high after a pause, the packet resumes with its next word, without a start strobe and without loss or repetition.
- R9: If rx_avail stays high and another complete packet is ready, tx_en is high with tx_sop in the cycle after the last word. Otherwise tx_en is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Enables odd parity generation |
| rx_avail | input | 1 | Receiver can take a complete packet (inverse of a full indication) |
| src_ready | input | 1 | At least one complete packet is waiting upstream |
| src_word | input | 32 | Head word of the upstream store |
| src_last | input | 1 | Head word is the last word of its packet |
| src_pop | output | 1 | Consumes the head word this cycle |
| tx_data | output | 32 | Transmit data word |
| tx_par | output | 1 | Odd parity over tx_data, or 0 when disabled |
| tx_sop | output | 1 | First word of a packet |
| tx_en | output | 1 | A valid word is on tx_data |

## Verification
The embedded assertions check, cycle by cycle, several local rules. Every pop is followed by the same word with tx_en high. The start strobe never appears without tx_en. Parity is odd when enabled and zero when disabled. The drain counter never exceeds its limit, and no word leaves once the limit is hit while the receiver is not ready. Some behaviours span whole packets and only the bench scenarios can show them. These are the exact count of four words after a withdrawal, resumption from the correct word, refusal to start while the receiver or the source is not ready, and the difference between back-to-back packets and a gap after the last word.

// File: rtl/egress_pkg.sv
package egress_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_HOLD = 2'd2
    } tx_state_e;
endpackage

// File: rtl/egress_drain_ctr.sv
module egress_drain_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_avail,
    input  logic word_go,
    input  logic pkt_end,
    output logic may_send
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Counts words sent while the receiver is withdrawn; cleared on readiness or packet end.
    always_ff @(posedge clk) begin
        if (rst || rx_avail || (word_go && pkt_end)) begin
            cnt_q <= '0;
        end else if (word_go) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        may_send = rx_avail || (cnt_q < CW'(LIMIT));
    end

    assert_drain_cap_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LIMIT));

    assert_no_word_past_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (!rx_avail && cnt_q == CW'(LIMIT)) |-> !word_go);
endmodule

// File: rtl/egress_seq_fsm.sv
module egress_seq_fsm
    import egress_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_avail,
    input  logic src_ready,
    input  logic src_last,
    input  logic may_send,
    output logic word_go,
    output logic first_word
);
    tx_state_e state_q;
    tx_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_avail && src_ready) begin
                    state_d = src_last ? ST_IDLE : ST_BODY;
                end
            end
            ST_BODY, ST_HOLD: begin
                if (may_send) begin
                    state_d = src_last ? ST_IDLE : ST_BODY;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        word_go    = 1'b0;
        first_word = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                word_go    = rx_avail && src_ready && !rst;
                first_word = word_go;
            end
            ST_BODY, ST_HOLD: begin
                word_go = may_send && !rst;
            end
            default: begin
                word_go    = 1'b0;
                first_word = 1'b0;
            end
        endcase
    end

    assert_start_needs_both_R2: assert property (@(posedge clk) disable iff (rst)
        first_word |-> (rx_avail && src_ready));

    assert_hold_is_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> $past(!may_send));
endmodule

// File: rtl/egress_parity.sv
module egress_parity #(
    parameter int W = 32
) (
    input  logic [W-1:0] data,
    input  logic         en,
    output logic         par
);
    always_comb begin
        par = en ? ~(^data) : 1'b0;
    end
endmodule

// File: rtl/egress_out_reg.sv
module egress_out_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         word_go,
    input  logic         first_word,
    input  logic [W-1:0] word_in,
    input  logic         par_in,
    input  logic         par_en,
    output logic [W-1:0] tx_data,
    output logic         tx_par,
    output logic         tx_sop,
    output logic         tx_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
            tx_par  <= 1'b0;
            tx_sop  <= 1'b0;
            tx_en   <= 1'b0;
        end else begin
            tx_en   <= word_go;
            tx_sop  <= word_go && first_word;
            tx_data <= word_go ? word_in : '0;
            tx_par  <= word_go ? par_in : 1'b0;
        end
    end

    assert_sop_with_en_R3: assert property (@(posedge clk) disable iff (rst)
        tx_sop |-> tx_en);

    assert_odd_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(par_en)) |-> (^{tx_data, tx_par}) == 1'b1);

    assert_parity_off_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(par_en) |-> !tx_par);
endmodule

// File: rtl/pkt_egress_tx.sv
module pkt_egress_tx #(
    parameter int DATA_W      = 32,
    parameter int DRAIN_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_en,
    input  logic              rx_avail,
    input  logic              src_ready,
    input  logic [DATA_W-1:0] src_word,
    input  logic              src_last,
    output logic              src_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_par,
    output logic              tx_sop,
    output logic              tx_en
);
    logic may_send;
    logic word_go;
    logic first_word;
    logic par_bit;

    egress_drain_ctr #(.LIMIT(DRAIN_WORDS)) u_drain (
        .clk      (clk),
        .rst      (rst),
        .rx_avail (rx_avail),
        .word_go  (word_go),
        .pkt_end  (src_last),
        .may_send (may_send)
    );

    egress_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rx_avail   (rx_avail),
        .src_ready  (src_ready),
        .src_last   (src_last),
        .may_send   (may_send),
        .word_go    (word_go),
        .first_word (first_word)
    );

    egress_parity #(.W(DATA_W)) u_par (
        .data (src_word),
        .en   (par_en),
        .par  (par_bit)
    );

    egress_out_reg #(.W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .word_go    (word_go),
        .first_word (first_word),
        .word_in    (src_word),
        .par_in     (par_bit),
        .par_en     (par_en),
        .tx_data    (tx_data),
        .tx_par     (tx_par),
        .tx_sop     (tx_sop),
        .tx_en      (tx_en)
    );

    always_comb begin
        src_pop = word_go;
    end

    assert_pop_then_word_R4: assert property (@(posedge clk) disable iff (rst)
        src_pop |=> (tx_en && tx_data == $past(src_word)));
endmodule

// File: tb/pkt_egress_tx_bench.sv
module pkt_egress_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        par_en = 1'b0;
    logic        rx_avail = 1'b0;
    logic        src_ready = 1'b0;
    logic [31:0] src_word = '0;
    logic        src_last = 1'b0;
    logic        src_pop;
    logic [31:0] tx_data;
    logic        tx_par;
    logic        tx_sop;
    logic        tx_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [32:0] src_q[$];   // {last, word}
    logic [33:0] exp_q[$];   // {sop, last, word}
    logic popped  = 1'b0;
    logic par_cap = 1'b0;
    bit   after_last = 1'b0;
    int   b2b_cnt = 0;
    int   gap_cnt = 0;

    always #4 clk = ~clk;

    pkt_egress_tx u_pkt_egress_tx (
        .clk(clk), .rst(rst), .par_en(par_en), .rx_avail(rx_avail),
        .src_ready(src_ready), .src_word(src_word), .src_last(src_last),
        .src_pop(src_pop), .tx_data(tx_data), .tx_par(tx_par),
        .tx_sop(tx_sop), .tx_en(tx_en)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Capture pop and parity enable at the edge
    always @(posedge clk) begin
        popped  <= src_pop;
        par_cap <= par_en;
    end

    // Upstream store model
    always @(negedge clk) begin
        if (popped && src_q.size() != 0) void'(src_q.pop_front());
        src_ready = (src_q.size() != 0);
        if (src_q.size() != 0) begin
            src_word = src_q[0][31:0];
            src_last = src_q[0][32];
        end else begin
            src_word = '0;
            src_last = 1'b0;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (after_last) begin
                if (tx_en) b2b_cnt++; else gap_cnt++;
            end
            after_last = 1'b0;
            if (tx_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected word", tx_data, 0);
                end else begin
                    logic [33:0] e;
                    e = exp_q.pop_front();
                    check(tx_data == e[31:0], "R4 data", tx_data, e[31:0]);
                    check(tx_sop == e[33], "R3/R8 sop", tx_sop, e[33]);
                    if (par_cap)
                        check(tx_par == ~(^e[31:0]), "R5 odd parity", tx_par, ~(^e[31:0]));
                    else
                        check(tx_par == 1'b0, "R6 parity off", tx_par, 0);
                    after_last = e[32];
                end
            end else begin
                check(tx_sop == 1'b0, "R3 sop without en", tx_sop, 0);
            end
        end
    end

    task automatic push_pkt(input int len, input logic [31:0] base);
        for (int i = 0; i < len; i++) begin
            logic [31:0] w;
            w = base ^ (32'h9E37_79B9 * (i + 1));
            src_q.push_back({(i == len - 1), w});
            exp_q.push_back({(i == 0), (i == len - 1), w});
        end
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
    endtask

    task automatic count_en(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tx_en) n++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int b0;
        int g0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_en == 0 && tx_sop == 0 && tx_par == 0 && tx_data == 0, "R1 reset outputs",
              {tx_en, tx_sop, tx_par}, 0);
        rst = 1'b0;

        // R2: packet ready but receiver not ready
        push_pkt(3, 32'h1111_0000);
        count_en(6, n);
        check(n == 0, "R2 no start while rx_avail low", n, 0);
        // R2: receiver ready, source empty later
        par_en = 1'b1;
        rx_avail = 1'b1;
        wait_empty();
        count_en(5, n);
        check(n == 0, "R2 no start while source empty", n, 0);

        // R9: back-to-back packets with parity on
        b0 = b2b_cnt;
        g0 = gap_cnt;
        push_pkt(4, 32'hA5A5_0000);
        push_pkt(2, 32'h8000_0001);
        push_pkt(1, 32'hFFFF_FFFF);
        wait_empty();
        check(b2b_cnt - b0 == 2, "R9 back-to-back follow", b2b_cnt - b0, 2);
        check(gap_cnt - g0 == 1, "R9 gap after final packet", gap_cnt - g0, 1);

        // R7/R8: withdrawal mid-packet, parity off
        par_en = 1'b0;
        @(negedge clk);
        push_pkt(12, 32'h0F0F_0000);
        for (int i = 0; i < 20 && !tx_en; i++) @(negedge clk);
        rx_avail = 1'b0;
        count_en(8, n);
        check(n == 4, "R7 four words after withdrawal", n, 4);
        check(tx_en == 1'b0, "R7 transfer halted", tx_en, 0);
        count_en(4, n);
        check(n == 0, "R7 stays halted", n, 0);
        rx_avail = 1'b1;
        count_en(12, n);
        check(n == 7, "R8 remaining words after resume", n, 7);
        wait_empty();

        // R7/R2: withdrawal near packet end, next packet must wait
        push_pkt(3, 32'h3C3C_0000);
        push_pkt(2, 32'h0000_00FF);
        for (int i = 0; i < 20 && !tx_en; i++) @(negedge clk);
        rx_avail = 1'b0;
        count_en(8, n);
        check(n == 2, "R7 only packet tail after withdrawal", n, 2);
        check(exp_q.size() == 2, "R2 next packet not started", exp_q.size(), 2);
        rx_avail = 1'b1;
        wait_empty();

        // R1: reset mid-transfer clears outputs
        push_pkt(6, 32'h7777_0000);
        for (int i = 0; i < 20 && !tx_en; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(tx_en == 0 && tx_data == 0 && tx_sop == 0, "R1 reset mid-packet",
              {tx_en, tx_sop}, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule